// File: doc/BRIEF.md
# Interleaved CPU/I/O Bus Arbiter

This block decides which node may drive a shared multiprocessor bus. Four processor nodes and one I/O node each raise a request line. When several nodes compete, ownership rotates through eight slots. Every processor slot is followed by an I/O slot, so the I/O node gets every second turn. Slots whose node is not requesting are skipped. On a quiet bus the first node to ask wins at once. The rotation pointer only breaks ties between requests that arrive in the same cycle.

The granted node keeps its one-hot grant until it pulses the transaction-done strobe. The following cycle is a free arbitration cycle. The I/O node can hold the bus across several transactions for locked operations: if it keeps the exclusive-request line high when it signals done, it keeps its grant with no gap. The lock ends at the first done strobe that comes while exclusive-request is low.

Several copies of the arbiter may sit on the bus. Only the copy whose enable input is high drives grants. A disabled copy keeps its grant outputs low and drops any tenure it holds.

Top module: `ilv_bus_arbiter`

## Requirements
- R1: After reset no grant is active, and the rotation pointer sits at the CPU0 slot. If every node requests in the same first cycle, CPU0 is granted.
- R2: At most one grant output is high in any cycle.
- R3: On an idle enabled bus, a request sampled at a clock edge produces its grant right after that edge.
- R4: With every node requesting continuously, grants follow CPU0, I/O, CPU1, I/O, CPU2, I/O, CPU3, I/O, and then the sequence repeats.
- R5: Rotation slots whose node is not requesting are skipped. The grant goes to the next requesting node in slot order.
- R6: A grant stays on until done_i is sampled high. After that, all grants are low for exactly one cycle before the next grant.
- R7: Requests that arrive together on an idle bus are resolved from the slot after the last granted slot.
- R8: If done_i and excl_req_i are sampled high together while the I/O node holds the grant, the I/O grant continues with no idle cycle. The rotation pointer does not advance.
- R9: A done_i sampled while excl_req_i is low releases an I/O grant, including one held under lock.
- R10: excl_req_i has no effect while a CPU holds the grant. A done_i releases that grant.
- R11: While enable_i is low all grants are low, and any held tenure is dropped. Arbitration resumes from the retained pointer once enable_i returns high.
- R12: done_i has no effect when no grant is active. With no requests pending, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Selects this copy as the active arbiter |
| cpu_req_i | input | NUM_CPU | Bus requests from the processor nodes |
| io_req_i | input | 1 | Bus request from the I/O node |
| excl_req_i | input | 1 | I/O node asks to keep the bus across transactions |
| done_i | input | 1 | Current owner finishes its transaction |
| cpu_gnt_o | output | NUM_CPU | One-hot grants to the processor nodes |
| io_gnt_o | output | 1 | Grant to the I/O node |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the done strobe and the exclusive request. When both are sampled together during an I/O tenure, the grant must persist. When done comes alone, the grant must drop. Directed sequences drive done_i with excl_req_i set and then cleared while processor requests stay pending. Grants are checked each cycle against a behavioural model, and against fixed expected owners.

The second pair is a fall of enable_i and a live or starting grant. Randomized traffic toggles enable, done and exclusive-request together, and the model judges every cycle.

// File: rtl/ilv_arb_pkg.sv
package ilv_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_LOCK = 2'd2
  } arb_state_e;
endpackage

// File: rtl/ilv_slot_pick.sv
// Rotated search over the interleaved slot ring: even slot 2k = CPU k, odd slot = I/O.
module ilv_slot_pick #(
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned SLOTS  = 2 * NUM_CPU,
  localparam int unsigned PTR_W  = $clog2(SLOTS)
) (
  input  logic [NUM_CPU-1:0] cpu_req_i,
  input  logic               io_req_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic               hit_o,
  output logic [PTR_W-1:0]   win_slot_o
);
  logic [SLOTS-1:0] slot_req;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s % 2 == 0) begin : g_cpu
      assign slot_req[s] = cpu_req_i[s/2];
    end else begin : g_io
      assign slot_req[s] = io_req_i;
    end
  end

  always_comb begin
    hit_o      = 1'b0;
    win_slot_o = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int unsigned idx;
      idx = (int'(ptr_i) + k) % SLOTS;
      if (!hit_o && slot_req[idx]) begin
        hit_o      = 1'b1;
        win_slot_o = PTR_W'(idx);
      end
    end
  end
endmodule

// File: rtl/ilv_grant_fsm.sv
module ilv_grant_fsm
  import ilv_arb_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned SLOTS  = 2 * NUM_CPU,
  localparam int unsigned PTR_W  = $clog2(SLOTS),
  localparam int unsigned NODES  = NUM_CPU + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             hit_i,
  input  logic [PTR_W-1:0] win_slot_i,
  input  logic             done_i,
  input  logic             excl_i,
  output logic [NODES-1:0] gnt_o,
  output logic [PTR_W-1:0] ptr_o
);
  arb_state_e       state_q, state_d;
  logic [NODES-1:0] gnt_q, gnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [NODES-1:0] win_oh;
  logic [PTR_W-1:0] ptr_next;

  // slot -> node one-hot; MSB is the I/O node
  always_comb begin
    win_oh = '0;
    if (win_slot_i[0]) begin
      win_oh[NUM_CPU] = 1'b1;
    end else begin
      for (int n = 0; n < NUM_CPU; n++) begin
        if (int'(win_slot_i >> 1) == n) win_oh[n] = 1'b1;
      end
    end
  end

  assign ptr_next = (int'(win_slot_i) == SLOTS - 1) ? '0 : win_slot_i + 1'b1;

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    ptr_d   = ptr_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
      gnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (hit_i) begin
            state_d = ST_BUSY;
            gnt_d   = win_oh;
            ptr_d   = ptr_next;
          end
        end
        ST_BUSY, ST_LOCK: begin
          if (done_i) begin
            if (gnt_q[NUM_CPU] && excl_i) begin
              state_d = ST_LOCK;
            end else begin
              state_d = ST_IDLE;
              gnt_d   = '0;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          gnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      ptr_q   <= ptr_d;
    end
  end

  assign gnt_o = gnt_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/ilv_bus_arbiter.sv
module ilv_bus_arbiter #(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [NUM_CPU-1:0] cpu_req_i,
  input  logic               io_req_i,
  input  logic               excl_req_i,
  input  logic               done_i,
  output logic [NUM_CPU-1:0] cpu_gnt_o,
  output logic               io_gnt_o
);
  localparam int unsigned SLOTS = 2 * NUM_CPU;
  localparam int unsigned PTR_W = $clog2(SLOTS);
  localparam int unsigned NODES = NUM_CPU + 1;

  logic             hit;
  logic [PTR_W-1:0] win_slot;
  logic [PTR_W-1:0] ptr;
  logic [NODES-1:0] gnt;

  ilv_slot_pick #(.NUM_CPU(NUM_CPU)) u_pick (
    .cpu_req_i (cpu_req_i),
    .io_req_i  (io_req_i),
    .ptr_i     (ptr),
    .hit_o     (hit),
    .win_slot_o(win_slot)
  );

  ilv_grant_fsm #(.NUM_CPU(NUM_CPU)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .hit_i     (hit),
    .win_slot_i(win_slot),
    .done_i    (done_i),
    .excl_i    (excl_req_i),
    .gnt_o     (gnt),
    .ptr_o     (ptr)
  );

  // inactive copies keep their grant lines low
  assign cpu_gnt_o = gnt[NUM_CPU-1:0] & {NUM_CPU{enable_i}};
  assign io_gnt_o  = gnt[NUM_CPU] & enable_i;
endmodule

// File: rtl/ilv_bus_arbiter_chk.sv
module ilv_bus_arbiter_chk #(
  parameter int unsigned NUM_CPU = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic [NUM_CPU-1:0] cpu_req_i,
  input logic               io_req_i,
  input logic               excl_req_i,
  input logic               done_i,
  input logic [NUM_CPU-1:0] cpu_gnt_o,
  input logic               io_gnt_o
);
  logic [NUM_CPU:0] g;
  logic             any_req;
  assign g       = {io_gnt_o, cpu_gnt_o};
  assign any_req = (|cpu_req_i) || io_req_i;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(g));

  p_idle_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g == '0 && enable_i && any_req) |=> (g != '0 || !enable_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g != '0 && !done_i) |=> (!enable_i || g == $past(g)));

  p_excl_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_gnt_o && done_i && excl_req_i) |=> (io_gnt_o || !enable_i));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g != '0 && done_i && !(io_gnt_o && excl_req_i)) |=> (g == '0));

  p_cpu_no_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cpu_gnt_o) && done_i) |=> (cpu_gnt_o == '0));

  p_disabled_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (g == '0));

  p_no_req_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g == '0 && !any_req) |=> (g == '0));
endmodule

bind ilv_bus_arbiter ilv_bus_arbiter_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .cpu_req_i (cpu_req_i),
  .io_req_i  (io_req_i),
  .excl_req_i(excl_req_i),
  .done_i    (done_i),
  .cpu_gnt_o (cpu_gnt_o),
  .io_gnt_o  (io_gnt_o)
);

// File: tb/ilv_bus_arbiter_test.sv
module ilv_bus_arbiter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic [3:0] cpu_req_i = '0;
  logic       io_req_i = 1'b0;
  logic       excl_req_i = 1'b0;
  logic       done_i = 1'b0;
  logic [3:0] cpu_gnt_o;
  logic       io_gnt_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model: owner -1 none, 0..3 CPU, 4 I/O; ptr = slot index 0..7
  int m_owner = -1;
  int m_ptr = 0;

  always #5 clk_i = ~clk_i;

  ilv_bus_arbiter #(.NUM_CPU(4)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .cpu_req_i(cpu_req_i), .io_req_i(io_req_i), .excl_req_i(excl_req_i),
    .done_i(done_i), .cpu_gnt_o(cpu_gnt_o), .io_gnt_o(io_gnt_o)
  );

  function automatic logic [4:0] node_vec(int node);
    logic [4:0] v = '0;
    if (node >= 0) v[node] = 1'b1;
    return v;
  endfunction

  task automatic model_step(logic [3:0] c, logic io, logic ex, logic dn, logic en);
    if (!en) begin
      m_owner = -1;
    end else if (m_owner >= 0) begin
      if (dn && !(m_owner == 4 && ex)) m_owner = -1;
    end else begin
      for (int k = 0; k < 8; k++) begin
        int s = (m_ptr + k) % 8;
        int nd = (s % 2 == 1) ? 4 : s / 2;
        bit r = (nd == 4) ? io : c[nd];
        if (r) begin
          m_owner = nd;
          m_ptr = (s + 1) % 8;
          break;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    logic [4:0] act = {io_gnt_o, cpu_gnt_o};
    logic [4:0] exp = enable_i ? node_vec(m_owner) : 5'b0;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: grants actual=%b expected=%b", tag, act, exp);
    end
    checks++;
    if ($countones(act) > 1) begin
      failures++;
      $display("FAIL R2: grants actual=%b expected at most one bit", act);
    end
  endtask

  task automatic drive(logic [3:0] c, logic io, logic ex, logic dn, logic en, string tag);
    cpu_req_i = c; io_req_i = io; excl_req_i = ex; done_i = dn; enable_i = en;
    @(posedge clk_i);
    model_step(c, io, ex, dn, en);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic expect_node(int node, string tag);
    logic [4:0] act = {io_gnt_o, cpu_gnt_o};
    checks++;
    if (act !== node_vec(node)) begin
      failures++;
      $display("FAIL %s: grants actual=%b expected=%b", tag, act, node_vec(node));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    expect_node(-1, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_node(-1, "R1 idle after reset");

    // R1/R7: everyone at once -> CPU0
    drive(4'hF, 1, 0, 0, 1, "R1");
    expect_node(0, "R1 pointer at CPU0");

    // R4: full interleaved rotation
    begin
      int seq[9] = '{4, 1, 4, 2, 4, 3, 4, 0, 4};
      for (int i = 0; i < 9; i++) begin
        drive(4'hF, 1, 0, 1, 1, "R6 release");
        expect_node(-1, "R6 gap cycle");
        drive(4'hF, 1, 0, 0, 1, "R4");
        expect_node(seq[i], "R4 rotation order");
      end
    end
    drive(4'hF, 1, 0, 1, 1, "R6 release");
    // pointer now at slot 2 (CPU1); R5 skip: only CPU3 and I/O idle
    drive(4'b1000, 0, 0, 0, 1, "R5");
    expect_node(3, "R5 skip to CPU3");
    drive(4'b1010, 0, 0, 1, 1, "R6 release");
    // R7: CPU1 and CPU3 together, ptr at slot 7 -> wraps to CPU0 none, CPU1
    drive(4'b1010, 0, 0, 0, 1, "R7");
    expect_node(1, "R7 tie from pointer");
    // R6 hold
    for (int i = 0; i < 5; i++) begin
      drive(4'b1111, 1, 0, 0, 1, "R6 hold");
      expect_node(1, "R6 hold without done");
    end
    drive(4'b0000, 0, 0, 1, 1, "R6 release");
    expect_node(-1, "R6 release");
    // R12: done while idle, no requests
    for (int i = 0; i < 3; i++) begin
      drive(4'b0000, 0, 1, 1, 1, "R12");
      expect_node(-1, "R12 stray done");
    end
    // R3: lone request on idle bus
    drive(4'b0100, 0, 0, 0, 1, "R3");
    expect_node(2, "R3 first come");
    drive(4'b0000, 0, 0, 1, 1, "R6 release");
    // R8: I/O locked tenure with CPUs waiting
    drive(4'b0000, 1, 1, 0, 1, "R8");
    expect_node(4, "R8 io grant");
    for (int i = 0; i < 3; i++) begin
      drive(4'b1111, 1, 1, 1, 1, "R8");
      expect_node(4, "R8 locked keep");
    end
    // R9: release of lock
    drive(4'b1111, 1, 0, 1, 1, "R9");
    expect_node(-1, "R9 lock released");
    drive(4'b1111, 0, 0, 0, 1, "R8 pointer");
    expect_node(3, "R8 pointer kept after I/O slot 5");
    // R10: excl with CPU owner
    drive(4'b0000, 0, 1, 1, 1, "R10");
    expect_node(-1, "R10 excl ignored for CPU");
    // R11: disable mid-grant and with requests
    drive(4'b0001, 0, 0, 0, 1, "R11 setup");
    expect_node(0, "R11 setup grant");
    drive(4'b0001, 0, 0, 0, 0, "R11");
    expect_node(-1, "R11 disabled grant low");
    drive(4'b1111, 1, 1, 0, 0, "R11");
    expect_node(-1, "R11 disabled no grant");
    drive(4'b1111, 1, 0, 0, 1, "R11");
    expect_node(4, "R11 resume from pointer");

    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c = 4'($urandom);
      logic io = 1'($urandom);
      logic ex = ($urandom % 3) != 0;
      logic dn = ($urandom % 3) == 0;
      logic en = ($urandom % 16) != 0;
      drive(c, io, ex, dn, en, "R2 R5 R6 R8 R11 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule